// File: doc/BRIEF.md
# TDM Time-Slot Capture Sampler

This block is a diagnostic tap on the write side of a time-division-multiplexed data store that serves 32 serial streams. Each store write carries a 13-bit slot index and one data byte. A processor programs one index into a select register. Whenever a store write hits that index, the block copies the byte into one half of a 16-bit capture register. The frame-sync pulse flips which half receives the byte, so the two halves hold the picks from two neighbouring frames. Software reads both halves back in one access.

Software seldom knows the raw slot index. It knows the stream number, the line rate, the receive offset and the wanted slot. A purely combinational helper turns those four values into the 13-bit index. The helper scales the slot by the rate and adds the constant that matches that rate's pipeline delay. The stream number goes in the low 5 bits of the index.

Top module: `slotCaptureSampler`

## Requirements
- R1: Register address 0 is the select register. Bits 12:0 can be written and read back. Bits 15:13 always read as zero. The value after reset is 0x0000.
- R2: Register address 1 is the capture register. It reads 0x0000 after reset. Bits 7:0 hold capture byte 0 and bits 15:8 hold capture byte 1. A processor write to address 1 does not change it.
- R3: Each frame writes into exactly one half, and the half changes at every frameSync pulse. The frame that runs from reset to the first pulse writes byte 0. A captured byte can be read on the cycle after the store write.
- R4: A capture takes place only when storeWrEn is high and storeWrIdx equals the active index. A store write to any other index leaves both halves unchanged.
- R5: A write to the select register becomes the active index at the next frameSync pulse. Until that pulse, the old index keeps capturing.
- R6: If a frame has no store write at the selected slot, the half that belongs to that frame keeps its old byte.
- R7: A store write in the same cycle as a frameSync pulse belongs to the frame that is ending. It uses that frame's index and that frame's half.
- R8: For calcRate = 11 (16 Mbit/s), calcIdx = 32 × ((TS + RTO) mod 256) + stream.
- R9: For calcRate = 10 (8 Mbit/s), calcIdx = 32 × ((2 × (TS + RTO) + 2) mod 256) + stream.
- R10: For calcRate = 01 (4 Mbit/s), calcIdx = 32 × ((4 × (TS + RTO) + 6) mod 256) + stream.
- R11: For calcRate = 00 (2 Mbit/s), calcIdx = 32 × ((8 × (TS + RTO) + 14) mod 256) + stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Processor register write strobe |
| regAddr | input | 1 | Register select: 0 selects the select register, 1 selects the capture register |
| regWrData | input | 16 | Processor write data |
| regRdData | output | 16 | Read data for the register at regAddr (combinational) |
| frameSync | input | 1 | One-cycle frame boundary pulse |
| storeWrEn | input | 1 | Data store write strobe |
| storeWrIdx | input | 13 | Slot index of the store write |
| storeWrData | input | 8 | Byte of the store write |
| calcStream | input | 5 | Helper input: stream number |
| calcRate | input | 2 | Helper input: rate code (00 = 2, 01 = 4, 10 = 8, 11 = 16 Mbit/s) |
| calcTs | input | 8 | Helper input: wanted time slot |
| calcRto | input | 8 | Helper input: receive offset |
| calcIdx | output | 13 | Helper output: computed slot index |

## Verification
The hardest case to reach is the window after a select-register write but before the next frame boundary. In that window the processor has changed the index, yet the old index must still capture and the new one must not. The stimulus writes a new index in the middle of a frame and then hits both the new and the old slot before any sync pulse. This shows that only the old slot lands in the register. A second hard case is a store write in the same cycle as the sync pulse. A task drives both in one cycle and then checks that the byte went to the half of the frame that was ending.

// File: rtl/slotCapPkg.sv
package slotCapPkg;
  localparam int STREAM_W = 5;
  localparam int SLOT_W   = 8;
  localparam int IDX_W    = STREAM_W + SLOT_W;
  localparam int BYTE_W   = 8;
  localparam int REG_W    = 16;

  typedef struct packed {
    logic capLo;
    logic capHi;
  } capStrobes_t;
endpackage

// File: rtl/slotCapCtrl.sv
module slotCapCtrl
  import slotCapPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              frameSync,
  input  logic              storeWrEn,
  input  logic [IDX_W-1:0]  storeWrIdx,
  output logic [IDX_W-1:0]  selIdx,
  output capStrobes_t       strb
);
  logic [IDX_W-1:0] activeIdx;
  logic             hiSel;
  logic             slotHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selIdx <= '0;
    else if (regWrEn && !regAddr) selIdx <= regWrData[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeIdx <= '0;
      hiSel     <= 1'b0;
    end else if (frameSync) begin
      activeIdx <= selIdx;
      hiSel     <= ~hiSel;
    end
  end

  assign slotHit    = storeWrEn && (storeWrIdx == activeIdx);
  assign strb.capLo = slotHit && !hiSel;
  assign strb.capHi = slotHit && hiSel;

  a_r5_index_frame_locked: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> $stable(activeIdx));
  a_r3_half_flips: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (hiSel != $past(hiSel)));
  a_r3_half_holds: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> $stable(hiSel));
endmodule

// File: rtl/slotCapData.sv
module slotCapData
  import slotCapPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  capStrobes_t       strb,
  input  logic [BYTE_W-1:0] storeWrData,
  output logic [REG_W-1:0]  capWord
);
  localparam int HALVES = REG_W / BYTE_W;
  logic [HALVES-1:0] halfEn;
  assign halfEn = {strb.capHi, strb.capLo};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) capWord[h*BYTE_W +: BYTE_W] <= '0;
      else if (halfEn[h]) capWord[h*BYTE_W +: BYTE_W] <= storeWrData;
    end
  end

  a_r6_lo_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capLo |=> $stable(capWord[BYTE_W-1:0]));
  a_r6_hi_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capHi |=> $stable(capWord[REG_W-1:BYTE_W]));
  a_r3_one_half: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(capWord[BYTE_W-1:0]) || $stable(capWord[REG_W-1:BYTE_W])));
endmodule

// File: rtl/slotIdxCalc.sv
module slotIdxCalc
  import slotCapPkg::*;
(
  input  logic [STREAM_W-1:0] stream,
  input  logic [1:0]          rate,
  input  logic [SLOT_W-1:0]   ts,
  input  logic [SLOT_W-1:0]   rto,
  output logic [IDX_W-1:0]    idx
);
  logic [SLOT_W:0]   sum;
  logic [1:0]        shiftAmt;
  logic [SLOT_W-1:0] scaled;
  logic [SLOT_W-1:0] pipeAdj;
  logic [SLOT_W-1:0] slotOut;

  always_comb begin
    sum      = {1'b0, ts} + {1'b0, rto};
    shiftAmt = 2'd3 - rate;
    scaled   = SLOT_W'(sum << shiftAmt);
    pipeAdj  = SLOT_W'((2 << shiftAmt) - 2);
    slotOut  = scaled + pipeAdj;
    idx      = {slotOut, stream};
  end

  always_comb begin
    if (rate == 2'b11)
      a_r8_full_rate: assert (idx[IDX_W-1:STREAM_W] == SLOT_W'(ts + rto));
  end
endmodule

// File: rtl/slotCaptureSampler.sv
module slotCaptureSampler
  import slotCapPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        frameSync,
  input  logic        storeWrEn,
  input  logic [12:0] storeWrIdx,
  input  logic [7:0]  storeWrData,
  input  logic [4:0]  calcStream,
  input  logic [1:0]  calcRate,
  input  logic [7:0]  calcTs,
  input  logic [7:0]  calcRto,
  output logic [12:0] calcIdx
);
  logic [IDX_W-1:0] selIdx;
  logic [REG_W-1:0] capWord;
  capStrobes_t      strb;

  slotCapCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameSync(frameSync), .storeWrEn(storeWrEn),
    .storeWrIdx(storeWrIdx), .selIdx(selIdx), .strb(strb)
  );

  slotCapData i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .storeWrData(storeWrData),
    .capWord(capWord)
  );

  slotIdxCalc i_calc (
    .stream(calcStream), .rate(calcRate), .ts(calcTs), .rto(calcRto),
    .idx(calcIdx)
  );

  assign regRdData = regAddr ? capWord : {{(REG_W-IDX_W){1'b0}}, selIdx};
endmodule

// File: tb/test_slotCaptureSampler.sv
module test_slotCaptureSampler;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regAddr = 1'b0;
  logic [15:0] regWrData = '0, regRdData;
  logic        frameSync = 1'b0, storeWrEn = 1'b0;
  logic [12:0] storeWrIdx = '0;
  logic [7:0]  storeWrData = '0;
  logic [4:0]  calcStream = '0;
  logic [1:0]  calcRate = '0;
  logic [7:0]  calcTs = '0, calcRto = '0;
  logic [12:0] calcIdx;
  int testsRun = 0, testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slotCaptureSampler i_slotCaptureSampler (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic regWrite(input logic a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic a, input logic [15:0] exp);
    @(negedge clk); regAddr = a; #1;
    check(req, regRdData, exp);
  endtask

  task automatic storeWrite(input logic [12:0] idx, input logic [7:0] d, input logic withSync);
    @(negedge clk); storeWrEn = 1'b1; storeWrIdx = idx; storeWrData = d; frameSync = withSync;
    @(negedge clk); storeWrEn = 1'b0; frameSync = 1'b0;
  endtask

  task automatic syncPulse();
    @(negedge clk); frameSync = 1'b1;
    @(negedge clk); frameSync = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    readCheck("R1 reset select", 1'b0, 16'h0000);
    readCheck("R2 reset capture", 1'b1, 16'h0000);
  endtask

  task automatic testSelectReg();
    doReset();
    regWrite(1'b0, 16'hFFFF);
    readCheck("R1 upper bits zero", 1'b0, 16'h1FFF);
    regWrite(1'b0, 16'h0ABC);
    readCheck("R1 readback", 1'b0, 16'h0ABC);
  endtask

  task automatic testReadOnly();
    doReset();
    storeWrite(13'd0, 8'h3C, 1'b0);
    regWrite(1'b1, 16'hBEEF);
    readCheck("R2 capture write ignored", 1'b1, 16'h003C);
  endtask

  task automatic testAlternation();
    doReset();
    storeWrite(13'd0, 8'h5A, 1'b0);
    readCheck("R3 first frame byte 0", 1'b1, 16'h005A);
    regWrite(1'b0, 16'h0123);
    storeWrite(13'h0123, 8'h77, 1'b0);
    readCheck("R5 new index not yet active", 1'b1, 16'h005A);
    storeWrite(13'd0, 8'h66, 1'b0);
    readCheck("R5 old index still active", 1'b1, 16'h0066);
    syncPulse();
    storeWrite(13'h0123, 8'h22, 1'b0);
    readCheck("R3 second frame byte 1", 1'b1, 16'h2266);
    storeWrite(13'h0124, 8'h99, 1'b0);
    readCheck("R4 other slot ignored", 1'b1, 16'h2266);
    syncPulse();
    storeWrite(13'h0123, 8'h33, 1'b0);
    readCheck("R3 third frame byte 0", 1'b1, 16'h2233);
  endtask

  task automatic testHoldAndSync();
    syncPulse();
    syncPulse();
    readCheck("R6 idle frames hold", 1'b1, 16'h2233);
    storeWrite(13'h0123, 8'h44, 1'b0);
    readCheck("R6 parity kept across idle frames", 1'b1, 16'h2244);
    storeWrite(13'h0123, 8'h55, 1'b1);
    readCheck("R7 sync-cycle write to closing half", 1'b1, 16'h2255);
    storeWrite(13'h0123, 8'h66, 1'b0);
    readCheck("R7 next frame uses byte 1", 1'b1, 16'h6655);
  endtask

  function automatic logic [12:0] refIdx(input logic [1:0] r, input int s, input int t, input int o);
    int mul, add, slot;
    case (r)
      2'b11: begin mul = 1; add = 0; end
      2'b10: begin mul = 2; add = 2; end
      2'b01: begin mul = 4; add = 6; end
      default: begin mul = 8; add = 14; end
    endcase
    slot = (mul * (t + o) + add) % 256;
    return 13'(32 * slot + s);
  endfunction

  task automatic calcCase(input string req, input logic [1:0] r, input int s, input int t, input int o);
    @(negedge clk);
    calcRate = r; calcStream = 5'(s); calcTs = 8'(t); calcRto = 8'(o); #1;
    check(req, {3'b000, calcIdx}, {3'b000, refIdx(r, s, t, o)});
  endtask

  task automatic testCalc();
    calcCase("R8 16M", 2'b11, 7, 200, 100);
    calcCase("R8 16M zero", 2'b11, 31, 0, 0);
    calcCase("R9 8M", 2'b10, 3, 100, 90);
    calcCase("R9 8M wrap", 2'b10, 0, 127, 127);
    calcCase("R10 4M", 2'b01, 12, 40, 30);
    calcCase("R10 4M low", 2'b01, 1, 0, 1);
    calcCase("R11 2M", 2'b00, 21, 31, 31);
    calcCase("R11 2M low", 2'b00, 9, 2, 5);
  endtask

  initial begin
    fork
      begin
        testReset();
        testSelectReg();
        testReadOnly();
        testAlternation();
        testHoldAndSync();
        testCalc();
      end
      begin
        repeat (20000) @(posedge clk);
        testsRun++; testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule